// File: doc/BRIEF.md
# Static Memory External Bus Controller

This block connects an internal request port to an external asynchronous SRAM-style bus. It accepts single-beat reads and writes as well as 16-byte line transfers (fills and write-backs). It drives the external address, an active-low chip select, a one-bus-clock start strobe, a read strobe and four per-byte write enables. It samples an external wait input to stretch the strobe. The external device can be 16 or 32 bits wide.

The block runs on a tick clock at twice the bus clock rate, so that each tick is one half of a bus clock. Address and chip-select setup before the strobe and address hold after it are each programmable from 0.5 to 7.5 bus clocks in whole-cycle steps, through 3-bit fields. The strobe lasts one bus clock plus the programmed wait cycles, and it is stretched further while the wait input is held low. Chip select drops at the end of the strobe. With the default settings an access therefore takes two bus clocks, and chip select is inactive for half a bus clock between accesses.

Line transfers always start at the 16-byte aligned address, whatever the low address bits or operand size that caused them. They are always carried out at full device width, and the bus stays locked until the last beat is over.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is low and after release with no request, bus_cs_n, bus_bs_n and bus_rd_n are 1, bus_we_n is 4'hF, req_ready is 1, and beat_done and bus_locked are 0.
- R2: bus_bs_n is low for exactly two ticks (one bus clock) at the start of every beat.
- R3: Every beat has three phases. First, bus_cs_n is low with the strobe inactive for 2*cfg_setup+1 ticks. Next, the strobe is active with bus_cs_n low for 2*(cfg_waits+1) ticks when no wait is seen. Last, bus_cs_n is high for 2*cfg_hold+1 ticks. bus_addr holds one value for the whole beat, so with all fields at zero an access takes 4 ticks.
- R4: bus_wait_n is examined only at the end of the last programmed strobe tick. Each tick in which it is seen low there adds one strobe tick, and low values at earlier ticks have no effect.
- R5: A read drives bus_rd_n low during the strobe, with bus_we_n at 4'hF and the exact request address on bus_addr. rd_data is the full device width: bus_din on a 32-bit device, and {16'h0, bus_din[15:0]} on a 16-bit device.
- R6: A single write on a 32-bit device drives bus_we_n[i] low when req_be[i] is set, with bus_dout = req_wdata. On a 16-bit device, address bit 1 selects either req_be[3:2]/req_wdata[31:16] (when it is 1) or req_be[1:0]/req_wdata[15:0]. The selected enables appear on bus_we_n[1:0] and the selected data on bus_dout[15:0], with bus_we_n[3:2] held at 2'b11. bus_rd_n stays high throughout.
- R7: A line transfer (req_line=1) uses the request address with bits [3:0] cleared as its base. It runs 4 beats stepping by 4 on a 32-bit device, or 8 beats stepping by 2 on a 16-bit device. req_ready stays low and bus_locked stays high from acceptance to the end of the last hold, and each beat's setup follows the previous hold with no idle tick.
- R8: A line write enables every device-width lane on every beat. Beat k drives req_line_data[32k+:32] on a 32-bit device, or req_line_data[16k+:16] on bus_dout[15:0] on a 16-bit device.
- R9: beat_done is a one-tick pulse in the first tick after each strobe, together with rd_data for that beat. beat_last is high with it on the final beat, and a single access counts as its final beat.
- R10: The configuration and request inputs are captured when a request is accepted. Changing them during an access has no effect on that access.
- R11: req_ready is high only when the controller is idle, and a request is accepted on the clock edge where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dev32 | input | 1 | 1: 32-bit device, 0: 16-bit device |
| cfg_setup | input | 3 | Setup, 2n+1 ticks |
| cfg_hold | input | 3 | Hold, 2n+1 ticks |
| cfg_waits | input | WAIT_W | Programmed wait bus clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1: write, 0: read |
| req_line | input | 1 | 16-byte line transfer |
| req_addr | input | AW | Byte address |
| req_be | input | 4 | Byte enables of a single write |
| req_wdata | input | 32 | Single write data |
| req_line_data | input | 128 | Line write data, byte i at bits [8i+:8] |
| beat_done | output | 1 | One-tick pulse per finished beat |
| beat_last | output | 1 | Marks the final beat |
| rd_data | output | 32 | Read data of the finished beat |
| bus_addr | output | AW | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_bs_n | output | 1 | Bus cycle start strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 4 | Per-byte write enables, active low |
| bus_dout | output | 32 | Write data to the device |
| bus_oe | output | 1 | Data output enable during writes |
| bus_din | input | 32 | Read data from the device |
| bus_wait_n | input | 1 | External wait, active low |
| bus_locked | output | 1 | Bus held for a line transfer |

## Verification
The bench builds the block with AW=12 and WAIT_W=4, and keeps every address inside a 256-byte memory model, so that line bases, odd start addresses and both halfword selections occur often. A 4-bit wait field lets the random draws reach strobes of up to 12 ticks. With the 3-bit setup and hold fields covering 1 to 15 ticks each, every phase length is exercised, including the minimum 4-tick pitch. Wait-input noise before the final strobe tick, and configuration inputs changed during an access, show whether the design samples each of them at the right point.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int LINE_BYTES = 16;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int BEAT_W     = 3;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/sbc_beat_gen.sv
module sbc_beat_gen
    import sbc_pkg::*;
#(
    parameter int AW = 26
) (
    input  logic [AW-1:0]     base_addr,
    input  logic              line,
    input  logic              dev32,
    input  logic [BEAT_W-1:0] beat,
    input  logic [DATA_W-1:0] single_data,
    input  logic [LINE_W-1:0] line_data,
    output logic [AW-1:0]     beat_addr,
    output logic [DATA_W-1:0] beat_data,
    output logic              last_beat
);
    logic [3:0] offset;

    always_comb begin
        offset = dev32 ? {beat[1:0], 2'b00} : {beat, 1'b0};
        beat_addr = line ? {base_addr[AW-1:4], offset} : base_addr;
        if (!line) begin
            beat_data = single_data;
        end else if (dev32) begin
            beat_data = line_data[{beat[1:0], 5'b00000} +: DATA_W];
        end else begin
            beat_data = {16'h0000, line_data[{beat, 4'b0000} +: 16]};
        end
        last_beat = !line || (dev32 ? (beat[1:0] == 2'b11) : (beat == 3'b111));
    end
endmodule

// File: rtl/sbc_lane_map.sv
module sbc_lane_map
    import sbc_pkg::*;
(
    input  logic              dev32,
    input  logic              line,
    input  logic              half_sel,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        if (line) begin
            lane_en = dev32 ? 4'hF : 4'h3;
            dout    = data;
        end else if (dev32) begin
            lane_en = be;
            dout    = data;
        end else begin
            lane_en = {2'b00, half_sel ? be[3:2] : be[1:0]};
            dout    = {16'h0000, half_sel ? data[31:16] : data[15:0]};
        end
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sbc_pkg::*;
#(
    parameter int AW     = 26,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dev32,
    input  logic [2:0]        cfg_setup,
    input  logic [2:0]        cfg_hold,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_line,
    input  logic [AW-1:0]     req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [127:0]      req_line_data,
    output logic              beat_done,
    output logic              beat_last,
    output logic [31:0]       rd_data,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_cs_n,
    output logic              bus_bs_n,
    output logic              bus_rd_n,
    output logic [3:0]        bus_we_n,
    output logic [31:0]       bus_dout,
    output logic              bus_oe,
    input  logic [31:0]       bus_din,
    input  logic              bus_wait_n,
    output logic              bus_locked
);
    // Counter must hold 2*(2^WAIT_W) strobe ticks and 15 setup/hold ticks.
    localparam int CW = (WAIT_W + 2 > 4) ? WAIT_W + 2 : 4;

    typedef struct packed {
        phase_e              ph;
        logic [CW-1:0]       cnt;
        logic [1:0]          bs;
        logic [BEAT_W-1:0]   beat;
        logic                wr;
        logic                line;
        logic                dev32;
        logic [2:0]          setup;
        logic [2:0]          hold;
        logic [WAIT_W-1:0]   waits;
        logic [AW-1:0]       addr;
        logic [LANES-1:0]    be;
        logic [DATA_W-1:0]   wdata;
        logic [LINE_W-1:0]   lbuf;
        logic                done;
        logic                last;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0]     beat_addr;
    logic [DATA_W-1:0] beat_data;
    logic              last_beat;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] lane_dout;

    sbc_beat_gen #(.AW(AW)) u_beat (
        .base_addr   (r_q.addr),
        .line        (r_q.line),
        .dev32       (r_q.dev32),
        .beat        (r_q.beat),
        .single_data (r_q.wdata),
        .line_data   (r_q.lbuf),
        .beat_addr   (beat_addr),
        .beat_data   (beat_data),
        .last_beat   (last_beat)
    );

    sbc_lane_map u_lanes (
        .dev32    (r_q.dev32),
        .line     (r_q.line),
        .half_sel (r_q.addr[1]),
        .be       (r_q.be),
        .data     (beat_data),
        .lane_en  (lane_en),
        .dout     (lane_dout)
    );

    function automatic logic [CW-1:0] half_span(input logic [2:0] n);
        return CW'({n, 1'b1});
    endfunction

    function automatic logic [CW-1:0] strobe_span(input logic [WAIT_W-1:0] w);
        return CW'({w, 1'b0}) + CW'(2);
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.last = 1'b0;
        if (r_q.bs != 2'd0) begin
            r_d.bs = r_q.bs - 2'd1;
        end
        unique case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.ph    = PH_SETUP;
                    r_d.cnt   = half_span(cfg_setup);
                    r_d.bs    = 2'd2;
                    r_d.beat  = '0;
                    r_d.wr    = req_write;
                    r_d.line  = req_line;
                    r_d.dev32 = cfg_dev32;
                    r_d.setup = cfg_setup;
                    r_d.hold  = cfg_hold;
                    r_d.waits = cfg_waits;
                    r_d.addr  = req_line ? {req_addr[AW-1:4], 4'b0000} : req_addr;
                    r_d.be    = req_be;
                    r_d.wdata = req_wdata;
                    r_d.lbuf  = req_line_data;
                end
            end
            PH_SETUP: begin
                if (r_q.cnt == CW'(1)) begin
                    r_d.ph  = PH_STROBE;
                    r_d.cnt = strobe_span(r_q.waits);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            PH_STROBE: begin
                if (r_q.cnt != CW'(1)) begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end else if (bus_wait_n) begin
                    r_d.ph    = PH_HOLD;
                    r_d.cnt   = half_span(r_q.hold);
                    r_d.done  = 1'b1;
                    r_d.last  = last_beat;
                    r_d.rdata = r_q.dev32 ? bus_din : {16'h0000, bus_din[15:0]};
                end
            end
            PH_HOLD: begin
                if (r_q.cnt != CW'(1)) begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end else if (last_beat) begin
                    r_d.ph = PH_IDLE;
                end else begin
                    r_d.ph   = PH_SETUP;
                    r_d.cnt  = half_span(r_q.setup);
                    r_d.bs   = 2'd2;
                    r_d.beat = r_q.beat + BEAT_W'(1);
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.ph == PH_IDLE);
    assign beat_done  = r_q.done;
    assign beat_last  = r_q.last;
    assign rd_data    = r_q.rdata;
    assign bus_addr   = beat_addr;
    assign bus_cs_n   = !((r_q.ph == PH_SETUP) || (r_q.ph == PH_STROBE));
    assign bus_bs_n   = (r_q.bs == 2'd0);
    assign bus_rd_n   = !((r_q.ph == PH_STROBE) && !r_q.wr);
    assign bus_we_n   = ((r_q.ph == PH_STROBE) && r_q.wr) ? ~lane_en : 4'hF;
    assign bus_dout   = lane_dout;
    assign bus_oe     = r_q.wr && (r_q.ph != PH_IDLE);
    assign bus_locked = r_q.line && (r_q.ph != PH_IDLE);
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs_n,
    input logic          bus_bs_n,
    input logic          bus_rd_n,
    input logic [3:0]    bus_we_n,
    input logic [AW-1:0] bus_addr,
    input logic          req_ready,
    input logic          beat_done,
    input logic          bus_locked,
    input logic          dev32_q
);
    assert_bs_second_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_bs_n) |=> !bus_bs_n);

    assert_bs_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_bs_n && $past(!bus_bs_n)) |=> bus_bs_n);

    assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || (bus_we_n != 4'hF)) |-> !bus_cs_n);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

    assert_rd_we_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_n != 4'hF) |-> bus_rd_n);

    assert_narrow_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dev32_q |-> (bus_we_n[3:2] == 2'b11));

    assert_locked_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_locked |-> !req_ready);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |=> !beat_done);

    assert_busy_no_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready);
endmodule

bind sram_bus_ctrl sbc_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_bs_n   (bus_bs_n),
    .bus_rd_n   (bus_rd_n),
    .bus_we_n   (bus_we_n),
    .bus_addr   (bus_addr),
    .req_ready  (req_ready),
    .beat_done  (beat_done),
    .bus_locked (bus_locked),
    .dev32_q    (r_q.dev32)
);

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;
    localparam int AW = 12;
    localparam int WAIT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dev32 = 1'b1;
    logic [2:0] cfg_setup = '0, cfg_hold = '0;
    logic [WAIT_W-1:0] cfg_waits = '0;
    logic req_valid = 1'b0, req_write = 1'b0, req_line = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [127:0] req_line_data = '0;
    logic bus_wait_n = 1'b1;
    logic [31:0] bus_din;
    logic req_ready, beat_done, beat_last, bus_cs_n, bus_bs_n, bus_rd_n, bus_oe, bus_locked;
    logic [31:0] rd_data, bus_dout;
    logic [3:0] bus_we_n;
    logic [AW-1:0] bus_addr;

    int tests = 0;
    int fails = 0;
    bit cur_dev32 = 1'b1;
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    always #5 clk = ~clk;

    sram_bus_ctrl #(.AW(AW), .WAIT_W(WAIT_W)) u_dut (.*);

    // Device model: reads follow the address, writes land on enabled lanes.
    always_comb begin
        logic [7:0] a32, a16;
        a32 = {bus_addr[7:2], 2'b00};
        a16 = {bus_addr[7:1], 1'b0};
        if (cur_dev32) bus_din = {mem[a32+3], mem[a32+2], mem[a32+1], mem[a32]};
        else           bus_din = {16'hA5A5, mem[a16+1], mem[a16]};
    end

    always @(negedge clk) begin
        if (bus_we_n != 4'hF) begin
            if (cur_dev32) begin
                for (int i = 0; i < 4; i++)
                    if (!bus_we_n[i]) mem[{bus_addr[7:2], 2'(i)}] = bus_dout[8*i +: 8];
            end else begin
                for (int i = 0; i < 2; i++)
                    if (!bus_we_n[i]) mem[{bus_addr[7:1], 1'(i)}] = bus_dout[8*i +: 8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a, input bit d32);
        logic [7:0] a32, a16;
        a32 = {a[7:2], 2'b00};
        a16 = {a[7:1], 1'b0};
        return d32 ? {ref_mem[a32+3], ref_mem[a32+2], ref_mem[a32+1], ref_mem[a32]}
                   : {16'h0000, ref_mem[a16+1], ref_mem[a16]};
    endfunction

    // Runs one access starting at a negedge with the controller idle.
    task automatic run_access(input bit wr, input bit line, input bit d32,
                              input logic [7:0] addr, input logic [3:0] be,
                              input logic [31:0] wdata, input logic [127:0] lbuf,
                              input logic [2:0] s, input logic [2:0] h,
                              input logic [3:0] w, input int ext, input bit scramble);
        int nb, lt, st, ht;
        logic [7:0] base, ea;
        logic [3:0] emask;
        logic [31:0] edata;
        cur_dev32 = d32;
        cfg_dev32 = d32; cfg_setup = s; cfg_hold = h; cfg_waits = w;
        req_write = wr; req_line = line; req_addr = AW'(addr); req_be = be;
        req_wdata = wdata; req_line_data = lbuf; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R11 ready before accept", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin  // R10: inputs change after acceptance
            cfg_dev32 = ~d32; cfg_setup = ~s; cfg_hold = ~h; cfg_waits = ~w;
            req_addr = ~req_addr; req_be = ~be; req_wdata = ~wdata; req_line_data = ~lbuf;
            req_write = ~wr; req_line = ~line;
        end
        nb = line ? (d32 ? 4 : 8) : 1;
        lt = 2 * (int'(w) + 1); st = 2 * int'(s) + 1; ht = 2 * int'(h) + 1;
        base = {addr[7:4], 4'b0000};
        for (int b = 0; b < nb; b++) begin
            int setup_n, strobe_n, bs_n, hold_n, ext_left;
            bit addr_ok, lane_ok, order_ok, hold_ok, sact;
            setup_n = 0; strobe_n = 0; bs_n = 0; hold_n = 0; ext_left = ext;
            addr_ok = 1; lane_ok = 1; order_ok = 1; hold_ok = 1;
            ea = line ? base + 8'(b * (d32 ? 4 : 2)) : addr;
            if (line) begin
                emask = d32 ? 4'hF : 4'h3;
                edata = d32 ? lbuf[32*b +: 32] : {16'h0, lbuf[16*b +: 16]};
            end else if (d32) begin
                emask = be; edata = wdata;
            end else begin
                emask = {2'b00, addr[1] ? be[3:2] : be[1:0]};
                edata = {16'h0, addr[1] ? wdata[31:16] : wdata[15:0]};
            end
            while (!bus_cs_n) begin
                if (!bus_bs_n) bs_n++;
                if (bus_addr[7:0] != ea || bus_addr[AW-1:8] != '0) addr_ok = 0;
                sact = wr ? (bus_we_n != 4'hF) : !bus_rd_n;
                if (sact) begin
                    strobe_n++;
                    if (wr) begin
                        if (!bus_rd_n || bus_we_n != ~emask) lane_ok = 0;
                        if (d32 ? (bus_dout != edata) : (bus_dout[15:0] != edata[15:0])) lane_ok = 0;
                    end else if (bus_we_n != 4'hF) lane_ok = 0;
                    if (strobe_n >= lt && ext_left > 0) begin
                        bus_wait_n = 1'b0; ext_left--;
                    end else if (strobe_n < lt) bus_wait_n = 1'($urandom);
                    else bus_wait_n = 1'b1;
                end else if (strobe_n == 0) setup_n++;
                else order_ok = 0;
                @(negedge clk);
            end
            bus_wait_n = 1'b1;
            chk(setup_n == st, "R3 setup ticks", setup_n, st);
            chk(strobe_n == lt + ext && order_ok, "R4 strobe ticks with wait", strobe_n, lt + ext);
            chk(bs_n == 2, "R2 start strobe ticks", bs_n, 2);
            chk(addr_ok, "R7 beat address", bus_addr, ea);
            chk(lane_ok, wr ? (line ? "R8 line lanes" : "R6 write lanes") : "R5 read strobes",
                bus_we_n, ~emask);
            chk(beat_done && (beat_last == (b == nb - 1)), "R9 done/last", {beat_done, beat_last},
                {1'b1, 1'(b == nb - 1)});
            if (!wr) chk(rd_data == exp_rd(ea, d32), "R5 read data", rd_data, exp_rd(ea, d32));
            while (bus_cs_n && !req_ready) begin
                hold_n++;
                if (bus_addr[7:0] != ea) hold_ok = 0;
                if (hold_n > 1 && beat_done) hold_ok = 0;
                if (line && !bus_locked) hold_ok = 0;
                @(negedge clk);
            end
            chk(hold_n == ht && hold_ok, "R3 hold ticks", hold_n, ht);
            if (b < nb - 1)
                chk(!bus_cs_n && !req_ready && bus_locked, "R7 no idle between beats",
                    {bus_cs_n, req_ready}, 0);
            else
                chk(req_ready && !bus_locked, "R11 idle after access", req_ready, 1);
        end
        if (wr) begin
            bit same;
            if (line) begin
                for (int i = 0; i < 16; i++) ref_mem[base + 8'(i)] = lbuf[8*i +: 8];
            end else if (d32) begin
                for (int i = 0; i < 4; i++)
                    if (be[i]) ref_mem[{addr[7:2], 2'(i)}] = wdata[8*i +: 8];
            end else begin
                for (int i = 0; i < 2; i++)
                    if (emask[i]) ref_mem[{addr[7:1], 1'(i)}] = edata[8*i +: 8];
            end
            same = 1;
            for (int i = 0; i < 16; i++) if (mem[base + 8'(i)] != ref_mem[base + 8'(i)]) same = 0;
            chk(same, line ? "R8 line image" : "R6 write image", same, 1);
        end
    endtask

    initial begin
        #1_500_000;
        fails++; tests++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom); ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_bs_n && bus_rd_n && bus_we_n == 4'hF && req_ready && !beat_done
            && !bus_locked, "R1 in reset", {bus_cs_n, bus_bs_n, bus_rd_n, bus_we_n}, 7'h7F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_cs_n && bus_bs_n && bus_rd_n && bus_we_n == 4'hF && req_ready && !beat_done
            && !bus_locked, "R1 after reset", {bus_cs_n, bus_bs_n, bus_rd_n, bus_we_n}, 7'h7F);
        // Directed corners
        run_access(0, 0, 1, 8'h13, 4'h0, 0, 0, 0, 0, 0, 0, 0);             // minimum pitch, odd addr
        run_access(0, 1, 0, 8'h27, 4'h0, 0, 0, 0, 0, 0, 0, 0);             // narrow fill from odd addr
        run_access(1, 1, 1, 8'h35, 4'h0, 0, {4{32'hC0FFEE11}} ^ 128'h1234, 3, 2, 2, 2, 0);
        run_access(1, 0, 0, 8'h42, 4'hC, 32'hBEEF_0000, 0, 1, 1, 0, 0, 0); // upper half on 16-bit
        run_access(1, 0, 0, 8'h44, 4'h3, 32'h0000_7E57, 0, 0, 0, 1, 1, 0); // lower half on 16-bit
        run_access(0, 0, 0, 8'h42, 4'h0, 0, 0, 7, 7, 3, 3, 0);             // extra waits, narrow read
        run_access(0, 1, 1, 8'h5C, 4'h0, 0, 0, 1, 0, 1, 1, 1);             // inputs scrambled
        run_access(1, 0, 1, 8'h60, 4'h5, 32'hA1B2C3D4, 0, 0, 1, 0, 0, 1);
        for (int n = 0; n < 120; n++) begin
            bit wr, line, d32;
            logic [7:0] a;
            logic [3:0] be;
            wr = 1'($urandom); line = ($urandom % 10) < 3; d32 = 1'($urandom);
            a = 8'($urandom); be = 4'($urandom);
            if (d32 && be == 0) be = 4'h1;
            if (!d32 && a[1] && be[3:2] == 0) be[3] = 1'b1;
            if (!d32 && !a[1] && be[1:0] == 0) be[0] = 1'b1;
            run_access(wr, line, d32, a, be, $urandom,
                       {$urandom, $urandom, $urandom, $urandom},
                       3'($urandom), 3'($urandom), 4'($urandom % 6), int'($urandom % 4),
                       1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule